// File: doc/BRIEF.md
# Pipeline Hazard Stall and Bubble Controller

This block steers the pipeline registers of a five-stage in-order core (fetch, decode, execute, memory, write-back). Each cycle it looks at the instruction tags held in the decode, execute and memory registers, together with the resolved outcome of a conditional branch sitting in execute. From these it decides, for every stage, whether that stage's register keeps its old contents (stall) or is loaded with a no-op (bubble). It covers three hazards: a load whose result the next instruction reads, a conditional branch that was predicted taken but falls through, and a return whose target is unknown until it leaves the memory stage.

The block also holds the instruction-tag copy of the decode, execute, memory and write-back registers, so that the bubbles it inserts are visible and travel downstream the way a real no-op would. The fetch stage has no register here. The fetch unit reads the fetch stall output and re-presents the same instruction while that output is high. The datapath and the operand-forwarding multiplexers sit elsewhere. Branches are always predicted taken, so only a not-taken outcome counts as a misprediction.

An instruction tag is 16 bits wide: bits 15:12 hold the opcode, 11:8 the first source register, 7:4 the second source register and 3:0 the destination register. The opcode values are 0 no-op, 1 ALU, 2 load, 3 store, 4 conditional branch, 5 jump, 6 call and 7 return. Register code 15 means "no register". The control vectors are indexed by stage: bit 0 fetch, bit 1 decode, bit 2 execute, bit 3 memory, bit 4 write-back.

Top module: `hz_pipe_ctl`

## Requirements
- R1: While reset is high and in the cycle after it, every stage output reads the no-op tag 16'h0FFF, and all stall and bubble bits are 0.
- R2: A load-use hazard exists when execute holds a load (opcode 2) whose destination is not 15 and equals either source field of the decode instruction. In that cycle the fetch and decode stalls are 1, the execute bubble is 1 and the memory and write-back bits are 0.
- R3: A load whose destination is 15, or that matches neither decode source, causes no stall and no bubble.
- R4: A conditional branch (opcode 4) in execute with the taken input low sets the decode and execute bubbles. Fetch is not stalled for it. After the next edge, the decode and execute outputs both read 16'h0FFF.
- R5: A conditional branch in execute with the taken input high causes no bubble and no stall.
- R6: While a return (opcode 7) sits in decode, execute or memory, the fetch stall and the decode bubble are 1. When a return is fetched into a quiet pipeline, exactly three bubble cycles follow and the fetch stall lasts exactly three cycles.
- R7: When a load-use hazard and a pending return occur in the same cycle, decode is stalled and not bubbled.
- R8: No stage ever has stall and bubble set together. The memory and write-back bits are always 0.
- R9: A bubble loads opcode 0 and register code 15 in all three register fields (16'h0FFF).
- R10: With no hazard, each stage output takes the upstream stage's value on the next edge. A stalled decode register keeps its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| f_instr_i | input | 16 | Tag of the instruction fetched this cycle |
| e_taken_i | input | 1 | Resolved outcome of the branch in execute (1 = taken) |
| stall_o | output | 5 | Per-stage hold request, bit 0 fetch to bit 4 write-back |
| bubble_o | output | 5 | Per-stage no-op load request, same indexing |
| d_ir_o | output | 16 | Decode register tag |
| e_ir_o | output | 16 | Execute register tag |
| m_ir_o | output | 16 | Memory register tag |
| w_ir_o | output | 16 | Write-back register tag |

## Verification
The bench targets a load whose destination is the "no register" code, which a careless comparator would treat as a match and stall for. It also counts the bubbles after a return, where releasing at memory instead of write-back would show two bubbles instead of three. It drives a return into decode behind a dependent load: a design with the wrong priority bubbles decode and loses the return. It also checks a taken versus a not-taken branch, where a flipped outcome squashes good work or lets wrong-path instructions survive into memory.

// File: rtl/hz_pkg.sv
package hz_pkg;

    localparam int OP_W   = 4;
    localparam int RID_W  = 4;
    localparam int N_STG  = 5;

    localparam int STG_F = 0;
    localparam int STG_D = 1;
    localparam int STG_E = 2;
    localparam int STG_M = 3;
    localparam int STG_W = 4;

    typedef enum logic [OP_W-1:0] {
        OP_NOP   = 4'd0,
        OP_ALU   = 4'd1,
        OP_LOAD  = 4'd2,
        OP_STORE = 4'd3,
        OP_JCC   = 4'd4,
        OP_JMP   = 4'd5,
        OP_CALL  = 4'd6,
        OP_RET   = 4'd7
    } op_e;

    typedef logic [RID_W-1:0] rid_t;

    typedef struct packed {
        op_e  op;
        rid_t ra;
        rid_t rb;
        rid_t rd;
    } instr_t;

    localparam int   IW       = $bits(instr_t);
    localparam rid_t REG_NONE = '1;

    // Tag written into a register that receives a bubble.
    function automatic instr_t noop_tag();
        instr_t t;
        t.op = OP_NOP;
        t.ra = REG_NONE;
        t.rb = REG_NONE;
        t.rd = REG_NONE;
        return t;
    endfunction

    // True when a real destination register feeds one of the two sources.
    function automatic logic feeds_src(rid_t dst, rid_t sa, rid_t sb);
        return (dst != REG_NONE) && ((dst == sa) || (dst == sb));
    endfunction

endpackage

// File: rtl/hz_detect.sv
module hz_detect
    import hz_pkg::*;
(
    input  op_e  d_op,
    input  rid_t d_ra,
    input  rid_t d_rb,
    input  op_e  e_op,
    input  rid_t e_rd,
    input  op_e  m_op,
    input  logic e_taken,
    output logic load_use,
    output logic mispred,
    output logic ret_pend
);
    logic d_has_src;

    // A decode no-op reads nothing, so it cannot wait for a load.
    assign d_has_src = (d_op != OP_NOP);

    always_comb begin
        load_use = (e_op == OP_LOAD) && d_has_src && feeds_src(e_rd, d_ra, d_rb);
        mispred  = (e_op == OP_JCC) && !e_taken;
        ret_pend = (d_op == OP_RET) || (e_op == OP_RET) || (m_op == OP_RET);
    end
endmodule

// File: rtl/hz_ctrl.sv
module hz_ctrl
    import hz_pkg::*;
#(
    parameter int STAGES = N_STG
) (
    input  logic              load_use,
    input  logic              mispred,
    input  logic              ret_pend,
    output logic [STAGES-1:0] stall,
    output logic [STAGES-1:0] bubble
);
    always_comb begin
        stall  = '0;
        bubble = '0;
        // Fetch waits for a dependent load or an unresolved return target.
        stall[STG_F]  = load_use | ret_pend;
        // Decode holds its instruction behind a load; this wins over the return bubble.
        stall[STG_D]  = load_use;
        bubble[STG_D] = mispred | (ret_pend & ~load_use);
        // Execute gets a no-op behind a load or on a wrong-path instruction.
        bubble[STG_E] = mispred | load_use;
    end
endmodule

// File: rtl/hz_stage.sv
module hz_stage
    import hz_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   stall,
    input  logic   bubble,
    input  instr_t din,
    output instr_t dout
);
    always_ff @(posedge clk) begin
        if (rst || bubble) begin
            dout <= noop_tag();
        end else if (!stall) begin
            dout <= din;
        end
    end
endmodule

// File: rtl/hz_pipe_ctl.sv
module hz_pipe_ctl
    import hz_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [IW-1:0]    f_instr_i,
    input  logic             e_taken_i,
    output logic [N_STG-1:0] stall_o,
    output logic [N_STG-1:0] bubble_o,
    output logic [IW-1:0]    d_ir_o,
    output logic [IW-1:0]    e_ir_o,
    output logic [IW-1:0]    m_ir_o,
    output logic [IW-1:0]    w_ir_o
);
    instr_t           chain [N_STG];
    logic             load_use, mispred, ret_pend;
    logic [N_STG-1:0] stall, bubble;

    assign chain[STG_F] = instr_t'(f_instr_i);

    hz_detect u_det (
        .d_op     (chain[STG_D].op),
        .d_ra     (chain[STG_D].ra),
        .d_rb     (chain[STG_D].rb),
        .e_op     (chain[STG_E].op),
        .e_rd     (chain[STG_E].rd),
        .m_op     (chain[STG_M].op),
        .e_taken  (e_taken_i),
        .load_use (load_use),
        .mispred  (mispred),
        .ret_pend (ret_pend)
    );

    hz_ctrl #(.STAGES(N_STG)) u_ctl (
        .load_use (load_use),
        .mispred  (mispred),
        .ret_pend (ret_pend),
        .stall    (stall),
        .bubble   (bubble)
    );

    // One tag register per stage after fetch, each fed by its upstream neighbour.
    for (genvar s = 1; s < N_STG; s++) begin : g_stg
        hz_stage u_reg (
            .clk    (clk),
            .rst    (rst),
            .stall  (stall[s]),
            .bubble (bubble[s]),
            .din    (chain[s-1]),
            .dout   (chain[s])
        );
    end

    assign stall_o  = stall;
    assign bubble_o = bubble;
    assign d_ir_o   = chain[STG_D];
    assign e_ir_o   = chain[STG_E];
    assign m_ir_o   = chain[STG_M];
    assign w_ir_o   = chain[STG_W];
endmodule

// File: rtl/hz_checker.sv
module hz_checker
    import hz_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             e_taken_i,
    input logic [N_STG-1:0] stall_o,
    input logic [N_STG-1:0] bubble_o,
    input logic [IW-1:0]    d_ir_o,
    input logic [IW-1:0]    e_ir_o,
    input logic [IW-1:0]    m_ir_o
);
    instr_t d_t, e_t, m_t;
    logic   lu_seen, ret_seen;
    assign d_t = instr_t'(d_ir_o);
    assign e_t = instr_t'(e_ir_o);
    assign m_t = instr_t'(m_ir_o);
    assign lu_seen  = (e_t.op == OP_LOAD) && (d_t.op != OP_NOP) && feeds_src(e_t.rd, d_t.ra, d_t.rb);
    assign ret_seen = (d_t.op == OP_RET) || (e_t.op == OP_RET) || (m_t.op == OP_RET);

    a_r8_exclusive: assert property (@(posedge clk) disable iff (rst)
        (stall_o & bubble_o) == '0);

    a_r8_tail_free: assert property (@(posedge clk) disable iff (rst)
        (stall_o[STG_W:STG_M] == '0) && (bubble_o[STG_W:STG_M] == '0));

    a_r2_load_use: assert property (@(posedge clk) disable iff (rst)
        lu_seen |-> (stall_o[STG_F] && stall_o[STG_D] && bubble_o[STG_E]));

    a_r7_priority: assert property (@(posedge clk) disable iff (rst)
        (lu_seen && ret_seen) |-> !bubble_o[STG_D]);

    a_r6_ret_hold: assert property (@(posedge clk) disable iff (rst)
        ret_seen |-> stall_o[STG_F]);

    a_r4_squash: assert property (@(posedge clk) disable iff (rst)
        ((e_t.op == OP_JCC) && !e_taken_i) |=> (d_ir_o == noop_tag()) && (e_ir_o == noop_tag()));

    a_r10_hold: assert property (@(posedge clk) disable iff (rst)
        stall_o[STG_D] |=> (d_ir_o == $past(d_ir_o)));

    a_r9_noop: assert property (@(posedge clk) disable iff (rst)
        bubble_o[STG_E] |=> (e_t.op == OP_NOP) && (e_t.rd == REG_NONE));
endmodule

bind hz_pipe_ctl hz_checker u_chk (
    .clk       (clk),
    .rst       (rst),
    .e_taken_i (e_taken_i),
    .stall_o   (stall_o),
    .bubble_o  (bubble_o),
    .d_ir_o    (d_ir_o),
    .e_ir_o    (e_ir_o),
    .m_ir_o    (m_ir_o)
);

// File: tb/hz_pipe_ctl_tb.sv
module hz_pipe_ctl_tb;
    localparam int CLK_PERIOD = 10;
    localparam logic [15:0] NOOP = 16'h0FFF;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] f_instr = NOOP;
    logic        e_taken = 1'b0;
    logic [4:0]  stall_o, bubble_o;
    logic [15:0] d_ir_o, e_ir_o, m_ir_o, w_ir_o;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    logic [15:0] md = NOOP, me = NOOP, mm = NOOP, mw = NOOP;
    logic [4:0]  obs_st, obs_bb;
    int          cnt_dbub, cnt_fst;

    always #(CLK_PERIOD/2) clk = ~clk;

    hz_pipe_ctl u_dut (
        .clk(clk), .rst(rst), .f_instr_i(f_instr), .e_taken_i(e_taken),
        .stall_o(stall_o), .bubble_o(bubble_o),
        .d_ir_o(d_ir_o), .e_ir_o(e_ir_o), .m_ir_o(m_ir_o), .w_ir_o(w_ir_o)
    );

    function automatic logic [15:0] mk(input int op, input int ra, input int rb, input int rd);
        return {op[3:0], ra[3:0], rb[3:0], rd[3:0]};
    endfunction

    // Expected {bubble, stall} from the requirement text (R2, R4, R6, R7).
    function automatic logic [9:0] exp_ctl(input logic [15:0] d, input logic [15:0] e,
                                            input logic [15:0] m, input logic tk);
        logic lu, mp, rt;
        logic [4:0] st, bb;
        lu = (e[15:12] == 4'd2) && (d[15:12] != 4'd0) && (e[3:0] != 4'hF) &&
             ((e[3:0] == d[11:8]) || (e[3:0] == d[7:4]));
        mp = (e[15:12] == 4'd4) && !tk;
        rt = (d[15:12] == 4'd7) || (e[15:12] == 4'd7) || (m[15:12] == 4'd7);
        st = {3'b000, lu, lu | rt};
        bb = {2'b00, mp | lu, mp | (rt & ~lu), 1'b0};
        return {bb, st};
    endfunction

    task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic step(input logic [15:0] ins, input logic tk);
        logic [9:0]  ex;
        logic [15:0] nd, ne;
        string       tag;
        @(negedge clk);
        f_instr = ins;
        e_taken = tk;
        #1;
        ex = exp_ctl(md, me, mm, tk);
        obs_st = stall_o;
        obs_bb = bubble_o;
        if (bubble_o[1]) cnt_dbub++;
        if (stall_o[0])  cnt_fst++;
        if (ex[1] && ex[6] == 1'b0 && ex[0]) tag = "R2/R7 control";
        else if (ex[7] && !ex[1])            tag = "R4 control";
        else if (ex[0])                      tag = "R6 control";
        else                                 tag = "R10 control";
        check({bubble_o, stall_o} == ex, tag, {bubble_o, stall_o}, ex);
        check((stall_o & bubble_o) == 5'b0, "R8 exclusive", stall_o & bubble_o, 0);
        nd = ex[6] ? NOOP : (ex[1] ? md : ins);
        ne = ex[7] ? NOOP : md;
        mw = mm; mm = me; me = ne; md = nd;
        @(posedge clk);
        #1;
        check({d_ir_o, e_ir_o, m_ir_o, w_ir_o} == {md, me, mm, mw}, "R10 stage advance",
              {d_ir_o, e_ir_o, m_ir_o, w_ir_o}, {md, me, mm, mw});
    endtask

    task automatic flush();
        for (int i = 0; i < 6; i++) step(NOOP, 1'b1);
    endtask

    function automatic logic [15:0] rnd_instr();
        int op, ra, rb, rd;
        op = $urandom % 8;
        ra = ($urandom % 5 == 0) ? 15 : $urandom % 4;
        rb = ($urandom % 5 == 0) ? 15 : $urandom % 4;
        rd = ($urandom % 5 == 0) ? 15 : $urandom % 4;
        if (op == 7 && ($urandom % 3 != 0)) op = 1;
        return mk(op, ra, rb, rd);
    endfunction

    initial begin
        logic [15:0] held;
        void'($urandom(32'd4242));
        repeat (3) @(posedge clk);
        #1;
        // R1: reset state
        check({d_ir_o, e_ir_o, m_ir_o, w_ir_o} == {4{NOOP}}, "R1 reset tags",
              {d_ir_o, e_ir_o, m_ir_o, w_ir_o}, {4{NOOP}});
        check({stall_o, bubble_o} == 10'b0, "R1 reset control", {stall_o, bubble_o}, 0);
        @(negedge clk); rst = 1'b0;
        @(posedge clk); #1;
        check({stall_o, bubble_o} == 10'b0, "R1 after reset", {stall_o, bubble_o}, 0);

        // R2: dependent load
        step(mk(2, 1, 15, 5), 1'b1);
        step(mk(1, 5, 2, 6), 1'b1);
        step(NOOP, 1'b1);
        check(obs_st == 5'b00011 && obs_bb == 5'b00100, "R2 load-use pattern",
              {obs_st, obs_bb}, {5'b00011, 5'b00100});
        check(e_ir_o == NOOP, "R9 execute bubble tag", e_ir_o, NOOP);
        flush();

        // R3: load with no destination, and an unrelated load
        step(mk(2, 1, 15, 15), 1'b1);
        step(mk(1, 15, 15, 3), 1'b1);
        step(NOOP, 1'b1);
        check(obs_st == 0 && obs_bb == 0, "R3 no-dest load", {obs_st, obs_bb}, 0);
        step(mk(2, 1, 15, 2), 1'b1);
        step(mk(1, 3, 1, 4), 1'b1);
        step(NOOP, 1'b1);
        check(obs_st == 0 && obs_bb == 0, "R3 unrelated load", {obs_st, obs_bb}, 0);
        flush();

        // R4: not-taken branch squashes two wrong-path instructions
        step(mk(4, 15, 15, 15), 1'b0);
        step(mk(1, 1, 2, 3), 1'b0);
        step(mk(1, 2, 3, 1), 1'b0);
        check(obs_bb == 5'b00110 && obs_st == 0, "R4 mispredict pattern",
              {obs_st, obs_bb}, {5'b00000, 5'b00110});
        check(d_ir_o == NOOP && e_ir_o == NOOP, "R4 squashed tags", {d_ir_o, e_ir_o}, {NOOP, NOOP});
        flush();

        // R5: taken branch
        step(mk(4, 15, 15, 15), 1'b1);
        step(mk(1, 1, 2, 3), 1'b1);
        step(mk(1, 2, 3, 1), 1'b1);
        check(obs_bb == 0 && obs_st == 0, "R5 taken branch", {obs_st, obs_bb}, 0);
        check(e_ir_o == mk(1, 1, 2, 3), "R5 survivor", e_ir_o, mk(1, 1, 2, 3));
        flush();

        // R6: return gives three bubbles and three fetch-stall cycles
        cnt_dbub = 0; cnt_fst = 0;
        step(mk(7, 15, 15, 15), 1'b1);
        for (int i = 0; i < 7; i++) step(mk(1, 1, 1, 2), 1'b1);
        check(cnt_dbub == 3, "R6 bubble count", cnt_dbub, 3);
        check(cnt_fst == 3, "R6 fetch stall count", cnt_fst, 3);
        flush();

        // R7: dependent load together with a return in decode
        step(mk(2, 15, 15, 3), 1'b1);
        step(mk(7, 3, 15, 15), 1'b1);
        step(NOOP, 1'b1);
        check(obs_st[1] == 1'b1 && obs_bb[1] == 1'b0, "R7 decode stalled", {obs_st, obs_bb}, 5'b00011);
        check(d_ir_o == mk(7, 3, 15, 15), "R7 return kept", d_ir_o, mk(7, 3, 15, 15));
        flush();

        // Random mix checked against the bench model (R2, R4, R6, R8, R10)
        held = rnd_instr();
        for (int i = 0; i < 3000; i++) begin
            logic tk;
            tk = ($urandom % 2) == 1;
            step(held, tk);
            if (!obs_st[0]) held = rnd_instr();
        end

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule